// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register Window

This block is the register front end of an interrupt redirection controller with a parameterized number of input pins (24 by default). A bus agent reaches every internal register through two decoded offsets: it first writes an index into a select register, then reads or writes a 32-bit data window. The selected index reaches a version word, a writable ID, a read-only arbitration ID, or one 32-bit half of a 64-bit redirection entry per pin. Each entry takes two consecutive indexes, and its low half sits at the even index.

The block holds the redirection table and presents all of it, flattened, to the delivery engine. Within each entry the vector is in bits 7:0, the delivery mode in 10:8, the destination mode in 11, the polarity in 13, remote IRR in 14, the trigger mode in 15 (1 means level), the mask in 16 and the destination in 63:56. A write to an entry produces one-cycle pulses: one for a low-half write, one when the mask bit changes, and a service request when that pin is pending. The delivery engine sets remote IRR through a dedicated strobe. The delivery decisions themselves are made outside this block.

Top module: `irw_top`

## Requirements
- R1: Offset 0x00 is the select register. A write stores all 32 bits, and a read returns the stored value. Offset 0x10 is the data window. A read of any other offset returns 0, and a write to any other offset changes nothing.
- R2: Each read strobe gives `rd_valid` high for exactly the next cycle, with `rd_data` holding the result. No other strobe raises `rd_valid`.
- R3: A window read at select 1 returns (pin count − 1) in bits 23:16 and the version code 0x11 in bits 7:0, which is 0x00170011 by default. A window write at select 1 changes no state.
- R4: A window write at select 0 stores bits 27:24 of the data as the ID. A window read at select 0 or at select 2 returns the ID in bits 27:24 and zeros elsewhere. A window write at select 2 changes nothing.
- R5: For a select value s ≥ 0x10, the entry number is (s − 0x10) >> 1. An odd s selects bits 63:32 of the entry and an even s selects bits 31:0. A write replaces only that half, and the change shows in `tbl_flat` one cycle later.
- R6: A window access whose entry number is at or above the pin count, or whose select value is 3 to 0x0F, reads as 0 and its write is discarded.
- R7: A low-half write always leaves remote IRR (bit 14) at 0. A high-half write leaves it unchanged. `rirr_set_vld` sets it for `rirr_set_pin`.
- R8: A low-half write that changes the mask (bit 16) raises `mask_chg_pulse` for one cycle, the cycle after the write, together with the pin number and the new mask value. A write that leaves the mask unchanged raises no pulse.
- R9: Every low-half entry write raises `lo_wr_pulse` for one cycle, the cycle after the write, together with the pin number.
- R10: Every entry write, of either half, whose pin has `pin_pending` set at the write raises `svc_req` for one cycle, the cycle after the write, together with the pin number.
- R11: A write is accepted only when `req_size` is 4 or 8, and only data bits 31:0 are used. A write of any other size changes nothing and raises no pulse.
- R12: After reset, every entry equals 0x0000_0000_0001_0000 (only the mask set). The select register and the ID read 0, and no pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset within the region |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 32 | Write data (the low 32 bits of the access) |
| pin_pending | input | NPINS | Pending request bit of each pin, from the delivery engine |
| rirr_set_vld | input | 1 | Strobe that sets remote IRR |
| rirr_set_pin | input | PIN_W | Pin whose remote IRR is set |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| tbl_flat | output | NPINS*64 | Redirection table; entry i is at bits [64*i+63 : 64*i] |
| lo_wr_pulse | output | 1 | Low-half entry write occurred |
| lo_wr_pin | output | PIN_W | Pin of that low-half write |
| mask_chg_pulse | output | 1 | Mask bit changed |
| mask_chg_pin | output | PIN_W | Pin whose mask changed |
| mask_chg_val | output | 1 | New mask value |
| svc_req | output | 1 | Service request for a pending pin |
| svc_pin | output | PIN_W | Pin to service |

## Verification
The bench drives select values on both sides of every decode boundary: 2, 3, 0x0F, 0x10, the last valid index 0x3F and the first invalid index 0x40. If the entry number were derived wrongly, a write would land on the neighbouring pin or would wrap into pin 0, and the comparison of the full table would show it. It writes a low half with bit 14 set after the delivery engine has set remote IRR, and it writes a high half over a set remote IRR. A design that copied bit 14 through, or that cleared it on either half, would read back the wrong value. Further cases are a low-half write that leaves the mask unchanged, which must raise no pulse, and writes of size 1 and 2, which must leave every register unchanged.

// File: rtl/irw_pkg.sv
package irw_pkg;
    typedef enum logic [2:0] {
        IK_NONE,
        IK_ID,
        IK_VER,
        IK_ARB,
        IK_ENT
    } idx_kind_e;

    localparam logic [7:0] OFF_SEL    = 8'h00;
    localparam logic [7:0] OFF_WIN    = 8'h10;
    localparam logic [7:0] VER_CODE   = 8'h11;
    localparam int         RIRR_BIT   = 14;
    localparam int         MASK_BIT   = 16;
    localparam logic [31:0] SEL_ID    = 32'd0;
    localparam logic [31:0] SEL_VER   = 32'd1;
    localparam logic [31:0] SEL_ARB   = 32'd2;
    localparam logic [31:0] SEL_ENT0  = 32'h10;
endpackage

// File: rtl/irw_decode.sv
module irw_decode
    import irw_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int PIN_W = $clog2(NPINS)
) (
    input  logic [31:0]      sel,
    output idx_kind_e        kind,
    output logic [PIN_W-1:0] pin,
    output logic             hi_half
);
    localparam logic [31:0] NP32 = 32'(NPINS);

    logic [31:0] ent_num;

    always_comb begin
        ent_num = (sel - SEL_ENT0) >> 1;
        pin     = ent_num[PIN_W-1:0];
        hi_half = sel[0];
        if (sel == SEL_ID)                          kind = IK_ID;
        else if (sel == SEL_VER)                    kind = IK_VER;
        else if (sel == SEL_ARB)                    kind = IK_ARB;
        else if (sel >= SEL_ENT0 && ent_num < NP32) kind = IK_ENT;
        else                                        kind = IK_NONE;
    end
endmodule

// File: rtl/irw_entry.sv
module irw_entry
    import irw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        rirr_set,
    output logic [63:0] ent_q
);
    localparam logic [63:0] ENT_RST = 64'(1) << MASK_BIT;

    logic [63:0] ent_d;

    always_comb begin
        ent_d = ent_q;
        if (rirr_set)
            ent_d[RIRR_BIT] = 1'b1;
        if (wr_hi)
            ent_d[63:32] = wdata;
        if (wr_lo) begin
            ent_d[31:0]     = wdata;
            ent_d[RIRR_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q <= ENT_RST;
        else        ent_q <= ent_d;
    end

    // R7
    lo_clears_rirr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> !ent_q[RIRR_BIT]);

    // R5
    hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo && !rirr_set) |=> $stable(ent_q[31:0]));

    // R5
    lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> $stable(ent_q[63:32]));
endmodule

// File: rtl/irw_rdmux.sv
module irw_rdmux
    import irw_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int PIN_W = $clog2(NPINS)
) (
    input  logic             at_sel,
    input  logic             at_win,
    input  logic [31:0]      sel,
    input  idx_kind_e        kind,
    input  logic [PIN_W-1:0] pin,
    input  logic             hi_half,
    input  logic [3:0]       id,
    input  logic [63:0]      tbl [NPINS],
    output logic [31:0]      rdata
);
    localparam logic [7:0] MAXPIN = 8'(NPINS - 1);

    logic [31:0] win_word;

    always_comb begin
        case (kind)
            IK_ID, IK_ARB: win_word = {4'h0, id, 24'h0};
            IK_VER:        win_word = {8'h00, MAXPIN, 8'h00, VER_CODE};
            IK_ENT:        win_word = hi_half ? tbl[pin][63:32] : tbl[pin][31:0];
            default:       win_word = 32'h0;
        endcase
        if (at_sel)      rdata = sel;
        else if (at_win) rdata = win_word;
        else             rdata = 32'h0;
    end
endmodule

// File: rtl/irw_top.sv
module irw_top
    import irw_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int PIN_W = $clog2(NPINS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [7:0]            req_addr,
    input  logic [3:0]            req_size,
    input  logic [31:0]           req_wdata,
    input  logic [NPINS-1:0]      pin_pending,
    input  logic                  rirr_set_vld,
    input  logic [PIN_W-1:0]      rirr_set_pin,
    output logic                  rd_valid,
    output logic [31:0]           rd_data,
    output logic [NPINS*64-1:0]   tbl_flat,
    output logic                  lo_wr_pulse,
    output logic [PIN_W-1:0]      lo_wr_pin,
    output logic                  mask_chg_pulse,
    output logic [PIN_W-1:0]      mask_chg_pin,
    output logic                  mask_chg_val,
    output logic                  svc_req,
    output logic [PIN_W-1:0]      svc_pin
);
    typedef struct packed {
        logic [31:0]      sel;
        logic [3:0]       id;
        logic             rd_valid;
        logic [31:0]      rd_data;
        logic             lo_pulse;
        logic [PIN_W-1:0] lo_pin;
        logic             mc_pulse;
        logic [PIN_W-1:0] mc_pin;
        logic             mc_val;
        logic             svc;
        logic [PIN_W-1:0] svc_pin;
    } state_t;

    state_t st_d, st_q;

    idx_kind_e        kind;
    logic [PIN_W-1:0] dec_pin;
    logic             dec_hi;
    logic [31:0]      rd_word;
    logic             at_sel, at_win, size_ok, wr_ok, win_wr, ent_wr;
    logic [63:0]      tbl_arr [NPINS];
    logic [NPINS-1:0] wr_lo_vec, wr_hi_vec, rirr_vec;

    assign at_sel  = (req_addr == OFF_SEL);
    assign at_win  = (req_addr == OFF_WIN);
    assign size_ok = (req_size == 4'd4) || (req_size == 4'd8);
    assign wr_ok   = req_valid && req_write && size_ok;
    assign win_wr  = wr_ok && at_win;
    assign ent_wr  = win_wr && (kind == IK_ENT);

    irw_decode #(.NPINS(NPINS), .PIN_W(PIN_W)) u_decode (
        .sel     (st_q.sel),
        .kind    (kind),
        .pin     (dec_pin),
        .hi_half (dec_hi)
    );

    irw_rdmux #(.NPINS(NPINS), .PIN_W(PIN_W)) u_rdmux (
        .at_sel  (at_sel),
        .at_win  (at_win),
        .sel     (st_q.sel),
        .kind    (kind),
        .pin     (dec_pin),
        .hi_half (dec_hi),
        .id      (st_q.id),
        .tbl     (tbl_arr),
        .rdata   (rd_word)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_ent
        assign wr_lo_vec[g] = ent_wr && !dec_hi && (dec_pin == PIN_W'(g));
        assign wr_hi_vec[g] = ent_wr &&  dec_hi && (dec_pin == PIN_W'(g));
        assign rirr_vec[g]  = rirr_set_vld && (rirr_set_pin == PIN_W'(g));

        irw_entry u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo    (wr_lo_vec[g]),
            .wr_hi    (wr_hi_vec[g]),
            .wdata    (req_wdata),
            .rirr_set (rirr_vec[g]),
            .ent_q    (tbl_arr[g])
        );

        assign tbl_flat[64*g +: 64] = tbl_arr[g];
    end

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = req_valid && !req_write;
        st_d.lo_pulse = 1'b0;
        st_d.mc_pulse = 1'b0;
        st_d.svc      = 1'b0;
        if (req_valid && !req_write)
            st_d.rd_data = rd_word;
        if (wr_ok && at_sel)
            st_d.sel = req_wdata;
        if (win_wr && kind == IK_ID)
            st_d.id = req_wdata[27:24];
        if (ent_wr) begin
            st_d.svc     = pin_pending[dec_pin];
            st_d.svc_pin = dec_pin;
            if (!dec_hi) begin
                st_d.lo_pulse = 1'b1;
                st_d.lo_pin   = dec_pin;
                st_d.mc_pin   = dec_pin;
                st_d.mc_val   = req_wdata[MASK_BIT];
                st_d.mc_pulse = req_wdata[MASK_BIT] != tbl_arr[dec_pin][MASK_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid       = st_q.rd_valid;
    assign rd_data        = st_q.rd_data;
    assign lo_wr_pulse    = st_q.lo_pulse;
    assign lo_wr_pin      = st_q.lo_pin;
    assign mask_chg_pulse = st_q.mc_pulse;
    assign mask_chg_pin   = st_q.mc_pin;
    assign mask_chg_val   = st_q.mc_val;
    assign svc_req        = st_q.svc;
    assign svc_pin        = st_q.svc_pin;

    // R2
    rd_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    // R2
    no_spurious_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid);

    // R8
    mask_val_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_chg_pulse |-> (tbl_arr[mask_chg_pin][MASK_BIT] == mask_chg_val));

    // R8
    mask_needs_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_chg_pulse |-> lo_wr_pulse && (lo_wr_pin == mask_chg_pin));

    // R11
    bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !size_ok) |=>
            (!lo_wr_pulse && !svc_req && $stable(st_q.sel) && $stable(st_q.id)));
endmodule

// File: tb/irw_top_bench.sv
module irw_top_bench;
    localparam int NPINS = 24;
    localparam int PIN_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [7:0] req_addr = '0;
    logic [3:0] req_size = '0;
    logic [31:0] req_wdata = '0;
    logic [NPINS-1:0] pin_pending = '0;
    logic rirr_set_vld = 1'b0;
    logic [PIN_W-1:0] rirr_set_pin = '0;
    logic rd_valid;
    logic [31:0] rd_data;
    logic [NPINS*64-1:0] tbl_flat;
    logic lo_wr_pulse, mask_chg_pulse, mask_chg_val, svc_req;
    logic [PIN_W-1:0] lo_wr_pin, mask_chg_pin, svc_pin;

    always #5 clk = ~clk;

    irw_top #(.NPINS(NPINS), .PIN_W(PIN_W)) u_irw_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .pin_pending(pin_pending), .rirr_set_vld(rirr_set_vld),
        .rirr_set_pin(rirr_set_pin), .rd_valid(rd_valid), .rd_data(rd_data),
        .tbl_flat(tbl_flat), .lo_wr_pulse(lo_wr_pulse), .lo_wr_pin(lo_wr_pin),
        .mask_chg_pulse(mask_chg_pulse), .mask_chg_pin(mask_chg_pin),
        .mask_chg_val(mask_chg_val), .svc_req(svc_req), .svc_pin(svc_pin)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_sel;
    logic [3:0]  m_id;
    logic [63:0] m_tbl [NPINS];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        logic [31:0] idx;
        if (a == 8'h00) return m_sel;
        if (a != 8'h10) return 32'h0;
        if (m_sel == 0 || m_sel == 2) return {4'h0, m_id, 24'h0};
        if (m_sel == 1) return {8'h00, 8'(NPINS - 1), 8'h00, 8'h11};
        if (m_sel < 32'h10) return 32'h0;
        idx = (m_sel - 32'h10) >> 1;
        if (idx >= NPINS) return 32'h0;
        return m_sel[0] ? m_tbl[idx][63:32] : m_tbl[idx][31:0];
    endfunction

    task automatic check_table(input string tag);
        bit ok = 1;
        int bad = 0;
        for (int i = 0; i < NPINS; i++)
            if (tbl_flat[64*i +: 64] !== m_tbl[i]) begin ok = 0; bad = i; end
        chk(ok, tag, tbl_flat[64*bad +: 64], m_tbl[bad]);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [3:0] sz, input logic [31:0] d);
        bit e_lo = 0, e_mc = 0, e_svc = 0, e_mv = 0;
        logic [31:0] idx = '0;
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_size = sz; req_wdata = d;
        if (sz == 4 || sz == 8) begin
            if (a == 8'h00) m_sel = d;
            else if (a == 8'h10) begin
                if (m_sel == 0) m_id = d[27:24];
                else if (m_sel >= 32'h10 && ((m_sel - 32'h10) >> 1) < NPINS) begin
                    idx = (m_sel - 32'h10) >> 1;
                    e_svc = pin_pending[idx];
                    if (m_sel[0]) m_tbl[idx][63:32] = d;
                    else begin
                        e_lo = 1;
                        e_mv = d[16];
                        e_mc = d[16] != m_tbl[idx][16];
                        m_tbl[idx][31:0] = d;
                        m_tbl[idx][14] = 1'b0;
                    end
                end
            end
        end
        @(negedge clk);
        req_valid = 0;
        chk(lo_wr_pulse == e_lo && (!e_lo || lo_wr_pin == idx[4:0]), "R9 lo pulse",
            {lo_wr_pulse, lo_wr_pin}, {e_lo, idx[4:0]});
        chk(mask_chg_pulse == e_mc && (!e_mc || (mask_chg_pin == idx[4:0] && mask_chg_val == e_mv)),
            "R8 mask pulse", {mask_chg_pulse, mask_chg_pin, mask_chg_val}, {e_mc, idx[4:0], e_mv});
        chk(svc_req == e_svc && (!e_svc || svc_pin == idx[4:0]), "R10 service",
            {svc_req, svc_pin}, {e_svc, idx[4:0]});
        chk(!rd_valid, "R2 no rd_valid on write", rd_valid, 0);
    endtask

    task automatic bus_read(input logic [7:0] a, input string tag);
        logic [31:0] e;
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a; req_size = 4;
        e = model_read(a);
        @(negedge clk);
        req_valid = 0;
        chk(rd_valid == 1 && rd_data == e, tag, {rd_valid, rd_data}, {1'b1, e});
    endtask

    task automatic set_rirr(input int p);
        @(negedge clk);
        rirr_set_vld = 1; rirr_set_pin = 5'(p);
        m_tbl[p][14] = 1'b1;
        @(negedge clk);
        rirr_set_vld = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        m_sel = 0; m_id = 0;
        for (int i = 0; i < NPINS; i++) m_tbl[i] = 64'h0000_0000_0001_0000;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R12 reset state
        check_table("R12 reset table");
        chk(!lo_wr_pulse && !mask_chg_pulse && !svc_req, "R12 no pulses", 0, 0);
        bus_read(8'h00, "R12 select reads 0");
        bus_read(8'h10, "R12 id reads 0");

        // R3 version
        bus_write(8'h00, 4, 32'h1);
        bus_read(8'h10, "R3 version word");
        chk(model_read(8'h10) == 32'h0017_0011, "R3 version value", model_read(8'h10), 32'h0017_0011);
        bus_write(8'h10, 4, 32'hFFFF_FFFF);
        bus_read(8'h10, "R3 version write ignored");

        // R4 id / arb
        bus_write(8'h00, 4, 32'h0);
        bus_write(8'h10, 4, 32'hA5C3_1234);
        bus_read(8'h10, "R4 id readback");
        bus_write(8'h00, 8, 32'h2);
        bus_read(8'h10, "R4 arb mirrors id");
        bus_write(8'h10, 4, 32'h3000_0000);
        bus_read(8'h10, "R4 arb write ignored");

        // R1 other offsets
        bus_write(8'h20, 4, 32'h0000_0010);
        bus_read(8'h00, "R1 bad offset write ignored");
        bus_read(8'h20, "R1 bad offset reads 0");
        bus_read(8'h14, "R1 bad offset reads 0");

        // R5 / R7 / R8 / R9 entry 0 low and high
        pin_pending = 24'h000001;
        bus_write(8'h00, 4, 32'h10);
        bus_write(8'h10, 4, 32'h0000_C0A5);
        bus_read(8'h10, "R7 low write clears rirr");
        check_table("R5 low half in table");
        bus_write(8'h10, 4, 32'h0000_8033);
        bus_write(8'h00, 4, 32'h11);
        bus_write(8'h10, 4, 32'hAB00_0000);
        check_table("R5 high half in table");
        set_rirr(0);
        bus_write(8'h10, 4, 32'hCD00_0000);
        bus_write(8'h00, 4, 32'h10);
        bus_read(8'h10, "R7 high write keeps rirr");
        bus_write(8'h10, 4, 32'h0001_4000);
        bus_read(8'h10, "R7 rirr cleared again");

        // R6 boundaries
        bus_write(8'h00, 4, 32'h3F);
        bus_write(8'h10, 4, 32'h7700_0000);
        check_table("R5 last entry high");
        bus_write(8'h00, 4, 32'h40);
        bus_write(8'h10, 4, 32'h0000_0000);
        check_table("R6 out of range write discarded");
        bus_read(8'h10, "R6 out of range reads 0");
        bus_write(8'h00, 4, 32'h3);
        bus_read(8'h10, "R6 select 3 reads 0");
        bus_write(8'h00, 4, 32'hF);
        bus_write(8'h10, 4, 32'h1234_5678);
        bus_read(8'h10, "R6 select F reads 0");
        check_table("R6 select F write discarded");

        // R11 sizes
        bus_write(8'h00, 1, 32'h12);
        bus_read(8'h00, "R11 size 1 dropped");
        bus_write(8'h00, 4, 32'h12);
        bus_write(8'h10, 2, 32'h0);
        check_table("R11 size 2 dropped");

        // random phase
        for (int n = 0; n < 1500; n++) begin
            int op = $urandom_range(0, 9);
            logic [3:0] sz;
            case ($urandom_range(0, 5))
                0: sz = 1; 1: sz = 2; 2, 3: sz = 4; default: sz = 8;
            endcase
            pin_pending = 24'($urandom);
            if (op < 3) begin
                logic [31:0] s;
                case ($urandom_range(0, 4))
                    0: s = 32'($urandom_range(0, 15));
                    1: s = $urandom;
                    default: s = 32'h10 + 32'($urandom_range(0, 2*NPINS + 3));
                endcase
                bus_write(8'h00, sz, s);
            end else if (op < 6) begin
                logic [31:0] d = $urandom;
                if ($urandom_range(0, 1) == 1) d[14] = 1'b1;
                bus_write(($urandom_range(0, 7) == 0) ? 8'h08 : 8'h10, sz, d);
            end else if (op < 8) begin
                bus_read(8'h10, "R5 random window read");
            end else if (op == 8) begin
                set_rirr($urandom_range(0, NPINS - 1));
            end else begin
                bus_read(8'h00, "R1 random select read");
            end
            if (n % 25 == 0) check_table("R5 random table");
        end
        check_table("R5 final table");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule